// File: doc/BRIEF.md
# SERDES Interface Reset Sequencer

This block starts up a source-synchronous I/O interface in a fixed order of dependencies. It runs on the divided clock that also clocks the lanes. First it holds the clock generators in reset for as long as the system reset is high. After that reset clears, it waits until every clock generator reports lock. It then frees the delay-calibration controller and waits for that controller's ready flag. Next it frees the delay lines and the serializer/deserializer lanes together, with their enables still low. After a set number of divided-clock cycles it raises the lane enables and a done flag.

Every input is asynchronous to the divided clock, so each one passes through a two-flop synchronizer before the state machine reads it. The system reset can arrive at any time, and it returns the whole sequence to its start. If lock or ready is lost after start-up, the sequencer falls back to the state that waits for that flag. It holds every stage after that point in reset and drops the enables, then walks forward again once the flag returns.

Top module: `serdes_rst_seq`

## Requirements
- R1: While the system reset is high, and within 3 clock cycles after it is raised at any time, the outputs are: clock-generator reset 1, calibration reset 1, delay-line reset 1, every lane reset 1, every lane enable 0 and done 0.
- R2: The clock-generator reset goes low exactly 3 clock cycles after the system reset goes low. While the system reset is high, lock and ready flags have no effect on any output.
- R3: The calibration reset goes low 3 cycles after the last of the N_LOCK lock inputs goes high. It stays high while any single lock input is low.
- R4: The delay-line reset and all lane resets go low together, 3 cycles after ready goes high and only once the calibration reset is low. The lane enables stay 0 at that point.
- R5: The lane enables go high exactly ENA_DLY cycles after the lane resets go low, provided lock and ready stay high.
- R6: Done goes high in the same cycle as the lane enables and stays high while lock, ready and the system reset stay unchanged.
- R7: Within 3 cycles of any lock input going low, the calibration, delay-line and lane resets go high and the enables and done go low. The clock-generator reset stays low. When lock returns, the sequence resumes from the wait for lock.
- R8: Within 3 cycles of ready going low, the delay-line and lane resets go high and the enables and done go low. The calibration reset stays low.
- R9: If lock and ready are lost in the same cycle, the lock-loss outcome (R7) wins. If a loss of ready reaches the state machine in the same cycle as the enable delay runs out, the loss wins and the enables never rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock of the interface |
| sys_rst | input | 1 | System reset, active high, asynchronous |
| lock_in | input | N_LOCK | Lock flags of the clock generators, asynchronous |
| cal_rdy_in | input | 1 | Ready flag of the delay-calibration controller, asynchronous |
| clkgen_rst | output | 1 | Reset to the clock generators, active high |
| cal_rst | output | 1 | Reset to the delay-calibration controller, active high |
| dly_rst | output | 1 | Reset to the delay lines, active high |
| lane_rst | output | N_LANES | Per-lane serializer/deserializer reset, active high |
| lane_en | output | N_LANES | Per-lane enable, active high |
| seq_done | output | 1 | Sequence complete |

## Verification
Two events can land on the same edge. One is a loss of ready, or of lock, reaching the state machine in the same cycle as the enable delay runs out. The other is lock and ready being lost together. The bench sweeps the cycle at which ready drops, taken relative to the lane reset release, across the whole enable window. For each offset it computes whether the enables should have risen, and the tie offset must show no enable pulse. It also drops lock and ready together and checks that the calibration reset comes back high, not only the lane resets.

// File: rtl/serdes_rst_seq_pkg.sv
package serdes_rst_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_CLKGEN_RST = 3'd0,
    SEQ_WAIT_LOCK  = 3'd1,
    SEQ_WAIT_CAL   = 3'd2,
    SEQ_LANE_HOLD  = 3'd3,
    SEQ_RUN        = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic clkgen_rst;
    logic cal_rst;
    logic path_rst;
    logic lane_en;
    logic done;
  } seq_ctl_t;

  function automatic seq_ctl_t seq_decode(seq_state_e s);
    seq_ctl_t c;
    c.clkgen_rst = 1'b0;
    c.cal_rst    = 1'b1;
    c.path_rst   = 1'b1;
    c.lane_en    = 1'b0;
    c.done       = 1'b0;
    case (s)
      SEQ_CLKGEN_RST: c.clkgen_rst = 1'b1;
      SEQ_WAIT_LOCK:  ;
      SEQ_WAIT_CAL:   c.cal_rst = 1'b0;
      SEQ_LANE_HOLD: begin
        c.cal_rst  = 1'b0;
        c.path_rst = 1'b0;
      end
      SEQ_RUN: begin
        c.cal_rst  = 1'b0;
        c.path_rst = 1'b0;
        c.lane_en  = 1'b1;
        c.done     = 1'b1;
      end
      default: c.clkgen_rst = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int   WIDTH  = 1,
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain = {STAGES{INIT}};
    always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/rst_seq_dly_cnt.sv
module rst_seq_dly_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic run,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt = '0;

  assign expired = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!run)
      cnt <= '0;
    else if (!expired)
      cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import serdes_rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_s,
  input  logic       lock_ok,
  input  logic       cal_ok,
  input  logic       hold_over,
  output seq_state_e state_q,
  output seq_state_e state_n
);

  seq_state_e nxt;
  seq_state_e cur = SEQ_CLKGEN_RST;

  always_comb begin
    nxt = cur;
    case (cur)
      SEQ_CLKGEN_RST: nxt = SEQ_WAIT_LOCK;
      SEQ_WAIT_LOCK:  if (lock_ok) nxt = SEQ_WAIT_CAL;
      SEQ_WAIT_CAL: begin
        if (!lock_ok)    nxt = SEQ_WAIT_LOCK;
        else if (cal_ok) nxt = SEQ_LANE_HOLD;
      end
      SEQ_LANE_HOLD: begin
        if (!lock_ok)       nxt = SEQ_WAIT_LOCK;
        else if (!cal_ok)   nxt = SEQ_WAIT_CAL;
        else if (hold_over) nxt = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (!lock_ok)     nxt = SEQ_WAIT_LOCK;
        else if (!cal_ok) nxt = SEQ_WAIT_CAL;
      end
      default: nxt = SEQ_CLKGEN_RST;
    endcase
  end

  assign state_n = rst_s ? SEQ_CLKGEN_RST : nxt;
  assign state_q = cur;

  always_ff @(posedge clk) begin
    cur <= state_n;
  end

endmodule

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq
  import serdes_rst_seq_pkg::*;
#(
  parameter int N_LOCK      = 2,
  parameter int N_LANES     = 4,
  parameter int ENA_DLY     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               sys_rst,
  input  logic [N_LOCK-1:0]  lock_in,
  input  logic               cal_rdy_in,
  output logic               clkgen_rst,
  output logic               cal_rst,
  output logic               dly_rst,
  output logic [N_LANES-1:0] lane_rst,
  output logic [N_LANES-1:0] lane_en,
  output logic               seq_done
);

  logic              rst_s;
  logic [N_LOCK-1:0] lock_s;
  logic              lock_all_s;
  logic              rdy_s;
  logic              hold_over;
  seq_state_e        state_q;
  seq_state_e        state_n;
  seq_ctl_t          ctl_n;

  // Reset path starts asserted so the sequence is held from power-up.
  rst_seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_rst_sync (
    .clk (clk),
    .d   (sys_rst),
    .q   (rst_s)
  );

  rst_seq_sync #(.WIDTH(N_LOCK), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_lock_sync (
    .clk (clk),
    .d   (lock_in),
    .q   (lock_s)
  );

  rst_seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_rdy_sync (
    .clk (clk),
    .d   (cal_rdy_in),
    .q   (rdy_s)
  );

  assign lock_all_s = &lock_s;

  rst_seq_dly_cnt #(.LIMIT(ENA_DLY)) u_dly_cnt (
    .clk     (clk),
    .run     (state_q == SEQ_LANE_HOLD),
    .expired (hold_over)
  );

  rst_seq_fsm u_fsm (
    .clk       (clk),
    .rst_s     (rst_s),
    .lock_ok   (lock_all_s),
    .cal_ok    (rdy_s),
    .hold_over (hold_over),
    .state_q   (state_q),
    .state_n   (state_n)
  );

  assign ctl_n = seq_decode(state_n);

  // Outputs registered from the next state so they switch with the state.
  logic clkgen_q = 1'b1;
  logic cal_q    = 1'b1;
  logic dly_q    = 1'b1;
  logic done_q   = 1'b0;

  always_ff @(posedge clk) begin
    clkgen_q <= ctl_n.clkgen_rst;
    cal_q    <= ctl_n.cal_rst;
    dly_q    <= ctl_n.path_rst;
    done_q   <= ctl_n.done;
  end

  assign clkgen_rst = clkgen_q;
  assign cal_rst    = cal_q;
  assign dly_rst    = dly_q;
  assign seq_done   = done_q;

  // One register pair per lane keeps the fanout local to each lane.
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic rst_q = 1'b1;
    logic en_q  = 1'b0;
    always_ff @(posedge clk) begin
      rst_q <= ctl_n.path_rst;
      en_q  <= ctl_n.lane_en;
    end
    assign lane_rst[g] = rst_q;
    assign lane_en[g]  = en_q;
  end

endmodule

// File: rtl/serdes_rst_seq_chk.sv
module serdes_rst_seq_chk #(
  parameter int N_LANES = 4,
  parameter int ENA_DLY = 8
) (
  input logic               clk,
  input logic               rst_s,
  input logic               lock_all_s,
  input logic               rdy_s,
  input logic               clkgen_rst,
  input logic               cal_rst,
  input logic               dly_rst,
  input logic [N_LANES-1:0] lane_rst,
  input logic [N_LANES-1:0] lane_en,
  input logic               seq_done
);

  localparam int CW = $clog2(ENA_DLY + 2) + 1;

  logic [CW-1:0] since_rel = '0;

  always_ff @(posedge clk) begin
    if (lane_rst[0])
      since_rel <= '0;
    else if (since_rel != {CW{1'b1}})
      since_rel <= since_rel + CW'(1);
  end

  // R1
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst_s |=> (clkgen_rst && cal_rst && dly_rst && (&lane_rst) && !(|lane_en) && !seq_done));

  // R2
  a_r2_clkgen_after_rst: assert property (@(posedge clk) disable iff (rst_s)
    $fell(clkgen_rst) |-> !$past(rst_s));

  // R3
  a_r3_cal_after_lock: assert property (@(posedge clk) disable iff (rst_s)
    $fell(cal_rst) |-> $past(lock_all_s));

  // R4
  a_r4_lane_after_rdy: assert property (@(posedge clk) disable iff (rst_s)
    $fell(lane_rst[0]) |-> ($past(rdy_s) && !cal_rst && !dly_rst));

  // R5
  a_r5_enable_delay: assert property (@(posedge clk) disable iff (rst_s)
    $rose(lane_en[0]) |-> (since_rel == CW'(ENA_DLY)));

  // R6
  a_r6_done_with_en: assert property (@(posedge clk) disable iff (rst_s)
    $rose(seq_done) |-> $rose(lane_en[0]));

  // R7
  a_r7_lock_loss: assert property (@(posedge clk) disable iff (rst_s)
    !lock_all_s |=> (cal_rst && dly_rst && lane_rst[0] && !lane_en[0] && !seq_done));

  // R8
  a_r8_rdy_loss: assert property (@(posedge clk) disable iff (rst_s)
    !rdy_s |=> (dly_rst && lane_rst[0] && !lane_en[0] && !seq_done));

endmodule

bind serdes_rst_seq serdes_rst_seq_chk #(
  .N_LANES (N_LANES),
  .ENA_DLY (ENA_DLY)
) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .lock_all_s (lock_all_s),
  .rdy_s      (rdy_s),
  .clkgen_rst (clkgen_rst),
  .cal_rst    (cal_rst),
  .dly_rst    (dly_rst),
  .lane_rst   (lane_rst),
  .lane_en    (lane_en),
  .seq_done   (seq_done)
);

// File: tb/serdes_rst_seq_bench.sv
module serdes_rst_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_LOCK     = 2;
  localparam int N_LANES    = 2;
  localparam int ENA_DLY    = 4;
  localparam int OW         = 4 + 2 * N_LANES;

  logic               clk = 1'b0;
  logic               sys_rst = 1'b1;
  logic [N_LOCK-1:0]  lock_in = '0;
  logic               cal_rdy_in = 1'b0;
  logic               clkgen_rst;
  logic               cal_rst;
  logic               dly_rst;
  logic [N_LANES-1:0] lane_rst;
  logic [N_LANES-1:0] lane_en;
  logic               seq_done;
  logic [OW-1:0]      obs;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serdes_rst_seq #(
    .N_LOCK  (N_LOCK),
    .N_LANES (N_LANES),
    .ENA_DLY (ENA_DLY)
  ) u_serdes_rst_seq (
    .clk        (clk),
    .sys_rst    (sys_rst),
    .lock_in    (lock_in),
    .cal_rdy_in (cal_rdy_in),
    .clkgen_rst (clkgen_rst),
    .cal_rst    (cal_rst),
    .dly_rst    (dly_rst),
    .lane_rst   (lane_rst),
    .lane_en    (lane_en),
    .seq_done   (seq_done)
  );

  assign obs = {clkgen_rst, cal_rst, dly_rst, lane_rst, lane_en, seq_done};

  function automatic logic [OW-1:0] ev(logic ck, logic cal, logic path, logic en);
    return {ck, cal, path, {N_LANES{path}}, {N_LANES{en}}, en};
  endfunction

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [OW-1:0] exp);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", req, obs, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick(4);
    chk("R1 reset state", ev(1, 1, 1, 0));

    // R2: lock and ready have no effect while held in reset
    lock_in = '1;
    cal_rdy_in = 1'b1;
    tick(6);
    chk("R2 flags ignored in reset", ev(1, 1, 1, 0));
    lock_in = '0;
    cal_rdy_in = 1'b0;
    tick(3);

    sys_rst = 1'b0;
    tick(2);
    chk("R2 clkgen held for sync", ev(1, 1, 1, 0));
    tick(1);
    chk("R2 clkgen released", ev(0, 1, 1, 0));

    // R3: a partial lock is not enough
    lock_in = 2'b01;
    tick(6);
    chk("R3 partial lock 01", ev(0, 1, 1, 0));
    lock_in = 2'b10;
    tick(6);
    chk("R3 partial lock 10", ev(0, 1, 1, 0));
    lock_in = 2'b11;
    tick(2);
    chk("R3 cal held for sync", ev(0, 1, 1, 0));
    tick(1);
    chk("R3 cal released", ev(0, 0, 1, 0));

    tick(5);
    chk("R4 lanes wait for ready", ev(0, 0, 1, 0));
    cal_rdy_in = 1'b1;
    tick(2);
    chk("R4 lanes held for sync", ev(0, 0, 1, 0));
    tick(1);
    chk("R4 lanes released, enables off", ev(0, 0, 0, 0));

    for (int i = 1; i < ENA_DLY; i++) begin
      tick(1);
      chk("R5 enables wait", ev(0, 0, 0, 0));
    end
    tick(1);
    chk("R5 R6 enables and done", ev(0, 0, 0, 1));
    tick(10);
    chk("R6 done holds", ev(0, 0, 0, 1));

    // R8 and R9: sweep the ready drop across the enable window
    for (int k = 0; k <= ENA_DLY; k++) begin
      logic en_seen;
      logic en_exp;
      cal_rdy_in = 1'b0;
      tick(3);
      chk("R8 ready loss keeps cal released", ev(0, 0, 1, 0));
      cal_rdy_in = 1'b1;
      tick(3);
      chk("R4 lanes released again", ev(0, 0, 0, 0));
      en_seen = 1'b0;
      for (int j = 0; j < k; j++) begin
        tick(1);
        en_seen = en_seen | lane_en[0];
      end
      cal_rdy_in = 1'b0;
      for (int j = 0; j < 3; j++) begin
        tick(1);
        en_seen = en_seen | lane_en[0];
      end
      chk("R8 ready loss in window", ev(0, 0, 1, 0));
      en_exp = (k + 3 > ENA_DLY);
      checks++;
      if (en_seen !== en_exp) begin
        fails++;
        $display("FAIL R9 loss vs expiry k=%0d act=%b exp=%b", k, en_seen, en_exp);
      end
      cal_rdy_in = 1'b1;
      tick(3 + ENA_DLY);
      chk("R5 rerun after ready return", ev(0, 0, 0, 1));
    end

    // R7: lock loss from run
    lock_in = 2'b10;
    tick(2);
    chk("R7 run until sync", ev(0, 0, 0, 1));
    tick(1);
    chk("R7 lock loss", ev(0, 1, 1, 0));
    lock_in = 2'b11;
    tick(3);
    chk("R7 cal released on relock", ev(0, 0, 1, 0));
    tick(1);
    chk("R7 lanes follow ready", ev(0, 0, 0, 0));
    tick(ENA_DLY);
    chk("R7 rerun", ev(0, 0, 0, 1));

    // R9: lock and ready lost together
    lock_in = 2'b00;
    cal_rdy_in = 1'b0;
    tick(3);
    chk("R9 lock loss wins", ev(0, 1, 1, 0));
    lock_in = 2'b11;
    tick(3);
    chk("R9 cal released, waits ready", ev(0, 0, 1, 0));
    tick(4);
    chk("R9 still waits ready", ev(0, 0, 1, 0));
    cal_rdy_in = 1'b1;
    tick(3);
    chk("R4 lanes after ready", ev(0, 0, 0, 0));
    tick(ENA_DLY);
    chk("R5 run again", ev(0, 0, 0, 1));

    // R1: system reset while running
    sys_rst = 1'b1;
    tick(2);
    chk("R1 run until sync", ev(0, 0, 0, 1));
    tick(1);
    chk("R1 reset from run", ev(1, 1, 1, 0));
    sys_rst = 1'b0;
    tick(3);
    chk("R2 clkgen release after rerun", ev(0, 1, 1, 0));
    tick(1);
    chk("R3 cal with lock present", ev(0, 0, 1, 0));
    tick(1);
    chk("R4 lanes with ready present", ev(0, 0, 0, 0));
    tick(ENA_DLY);
    chk("R6 done after restart", ev(0, 0, 0, 1));

    finish_run();
  end

endmodule